// File: doc/BRIEF.md
# ATA PIO Command Sequencer

This block turns a stream of 16-bit command words into ATA-style programmed-I/O bus cycles. A command source presents one word at a time with a valid flag, and the block takes the word whenever it is idle. Register-read and register-write words each produce a single strobe cycle with the chip-select and device-address values carried in the word. Data-read and data-write words produce a burst of data-register cycles. A set-device word changes no bus pins. It picks which device's timing bank the following commands use, and whether the burst length counts single 16-bit words or 8-byte blocks.

Every bus cycle has four phases: address setup, strobe pulse, data hold and recovery. Each phase lasts for a count taken from a per-device timing word. If IORDY is enabled for the selected device, the device can stretch the strobe. Read data is captured as the strobe ends and appears with a one-cycle valid pulse. Write data for bursts is taken from a data input, and each captured word is acknowledged. Words that match no command are dropped, and they raise a sticky error flag.

Top module: `ata_pio_seq`

## Requirements
- R1: A word with bits [15:13]=001 is a register read. It drives cs_n_o with bits [12:11] and da_o with bits [10:8] through the setup, strobe and hold phases, makes exactly one DIOR# low pulse, and returns dd_i as read data.
- R2: A word with bits [15:13]=101 is a register write. It uses the same chip-select and address fields and makes one DIOW# low pulse. It drives {8'h00, bits [7:0]} on dd_o_o with dd_oe_o high from the start of setup to the end of hold.
- R3: A word with bits [14:13]=10 is a data command. Bit 15 selects write (1) or read (0), and bits [12:0] hold N, which gives N+1 data cycles with cs_n_o=2'b10 and da_o=0. A data write latches wdata_i once per cycle and pulses wdata_ack_o in the next clock.
- R4: A word with bits [15:2]=0x2740 is set-device. Bit 0 selects device 1 (else device 0), and bit 1 turns on block mode, in which a data command runs 4*(N+1) cycles. The word starts no bus cycle and leaves busy_o low.
- R5: Register cycles take their phase counts from the selected device's command timing word, and data cycles take them from its data timing word. In each word, bits [7:0] are setup, [15:8] strobe, [23:16] hold and [31:24] recovery.
- R6: The phases run in the order setup, strobe, hold, recovery. Each lasts its count in clocks, and a count of 0 lasts 1 clock. The strobes are low only in the strobe phase, and cs_n_o is 2'b11 in recovery and when idle.
- R7: When iordy_en_i has the bit of the selected device set, the strobe stays low past its count until iordy_i is high. When that bit is clear, iordy_i has no effect.
- R8: Read data is sampled from dd_i on the clock edge at which the strobe ends. rdata_valid_o is high for exactly the following clock.
- R9: xfer_cnt_o holds the number of bus cycles left in the current command, counting the one in progress, and decrements at the end of each cycle. It is 0 when the block is idle.
- R10: A word that matches no command is consumed without a bus cycle and sets err_o. err_o stays set until err_clr_i is pulsed.
- R11: After reset the block is idle. Strobes and chip selects are inactive, device 0 and word counting are selected, and err_o and xfer_cnt_o are 0.
- R12: cmd_ready_o is high only while idle. busy_o rises in the clock after a bus command is accepted and stays high until its last recovery phase ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command word available |
| cmd_word_i | input | 16 | Command word |
| cmd_ready_o | output | 1 | Command word taken this clock |
| wdata_i | input | DATA_W | Write data for data-write bursts |
| wdata_ack_o | output | 1 | One write word was latched in the previous clock |
| cmd_tim0_i | input | 4*FLD_W | Device 0 register-cycle timing |
| dat_tim0_i | input | 4*FLD_W | Device 0 data-cycle timing |
| cmd_tim1_i | input | 4*FLD_W | Device 1 register-cycle timing |
| dat_tim1_i | input | 4*FLD_W | Device 1 data-cycle timing |
| iordy_en_i | input | 2 | Per-device IORDY enable |
| err_clr_i | input | 1 | Clears the sticky error flag |
| iordy_i | input | 1 | Device ready (synchronised) |
| dd_i | input | DATA_W | Bus data in |
| dd_o_o | output | DATA_W | Bus data out |
| dd_oe_o | output | 1 | Bus data output enable |
| cs_n_o | output | 2 | Chip selects, active low |
| da_o | output | 3 | Device address |
| dior_n_o | output | 1 | Read strobe, active low |
| diow_n_o | output | 1 | Write strobe, active low |
| rdata_o | output | DATA_W | Captured read data |
| rdata_valid_o | output | 1 | Read data valid pulse |
| busy_o | output | 1 | Bus command in progress |
| dev_sel_o | output | 1 | Selected device |
| xfer_cnt_o | output | XFER_W | Bus cycles remaining |
| err_o | output | 1 | Sticky bad-command flag |

## Verification
A phase counter that is loaded from the wrong bank or field shows at once as a strobe pulse or busy period of the wrong length. The bench catches this in the command's own run by counting low strobe cycles and busy cycles. A burst counter that is off by one or that ignores block mode gives the wrong number of read-valid or write-acknowledge pulses. It also leaves xfer_cnt_o wrong in the first clock after acceptance. A decode fault shows as a wrong chip-select or address while the strobe is low, or as a dropped word that raises err_o and produces no busy period.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam int unsigned CMD_W = 16;
  localparam logic [13:0] SETDEV_KEY = 14'h2740;

  typedef enum logic [2:0] {
    CK_BAD, CK_REG_RD, CK_REG_WR, CK_DAT_RD, CK_DAT_WR, CK_SETDEV
  } cmd_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_RECOV
  } phase_e;
endpackage

// File: rtl/ata_cmd_decode.sv
module ata_cmd_decode
  import ata_pio_pkg::*;
#(
  parameter int unsigned N_W = 13
) (
  input  logic [CMD_W-1:0] word_i,
  output cmd_kind_e        kind_o,
  output logic [1:0]       cs_n_o,
  output logic [2:0]       da_o,
  output logic [7:0]       byte_o,
  output logic [N_W-1:0]   count_o,
  output logic             dev_o,
  output logic             blk_o
);
  always_comb begin
    kind_o = CK_BAD;
    if (word_i[15:2] == SETDEV_KEY)     kind_o = CK_SETDEV;
    else if (word_i[15:13] == 3'b001)   kind_o = CK_REG_RD;
    else if (word_i[15:13] == 3'b101)   kind_o = CK_REG_WR;
    else if (word_i[14:13] == 2'b10)    kind_o = word_i[15] ? CK_DAT_WR : CK_DAT_RD;
  end

  assign cs_n_o  = word_i[12:11];
  assign da_o    = word_i[10:8];
  assign byte_o  = word_i[7:0];
  assign count_o = word_i[N_W-1:0];
  assign dev_o   = word_i[0];
  assign blk_o   = word_i[1];
endmodule

// File: rtl/ata_phase_engine.sv
module ata_phase_engine
  import ata_pio_pkg::*;
#(
  parameter int unsigned FLD_W = 8,
  localparam int unsigned TIM_W = 4 * FLD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             again_i,
  input  logic [TIM_W-1:0] tim_i,
  input  logic             iordy_gate_i,
  output phase_e           phase_o,
  output logic             strobe_end_o,
  output logic             cyc_end_o
);
  function automatic logic [FLD_W-1:0] len(input logic [FLD_W-1:0] f);
    return (f == '0) ? FLD_W'(1) : f;
  endfunction

  phase_e             phase_q;
  logic [FLD_W-1:0]   cnt_q;
  logic [TIM_W-1:0]   tim_q;
  logic               last;

  assign last         = (cnt_q == FLD_W'(1));
  assign strobe_end_o = (phase_q == PH_STROBE) && last && iordy_gate_i;
  assign cyc_end_o    = (phase_q == PH_RECOV) && last;
  assign phase_o      = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      tim_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          tim_q   <= tim_i;
          phase_q <= PH_SETUP;
          cnt_q   <= len(tim_i[FLD_W-1:0]);
        end
        PH_SETUP: if (last) begin
          phase_q <= PH_STROBE;
          cnt_q   <= len(tim_q[2*FLD_W-1:FLD_W]);
        end else cnt_q <= cnt_q - 1'b1;
        PH_STROBE: if (last) begin
          // hold at the final count while the device stretches the pulse
          if (iordy_gate_i) begin
            phase_q <= PH_HOLD;
            cnt_q   <= len(tim_q[3*FLD_W-1:2*FLD_W]);
          end
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (last) begin
          phase_q <= PH_RECOV;
          cnt_q   <= len(tim_q[4*FLD_W-1:3*FLD_W]);
        end else cnt_q <= cnt_q - 1'b1;
        PH_RECOV: if (last) begin
          if (again_i) begin
            phase_q <= PH_SETUP;
            cnt_q   <= len(tim_q[FLD_W-1:0]);
          end else begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
          end
        end else cnt_q <= cnt_q - 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ata_xfer_cnt.sv
module ata_xfer_cnt #(
  parameter int unsigned XFER_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [XFER_W-1:0] load_val_i,
  input  logic              dec_i,
  output logic [XFER_W-1:0] cnt_o,
  output logic              more_o
);
  logic [XFER_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign more_o = (cnt_q > XFER_W'(1));
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FLD_W  = 8,
  parameter int unsigned N_W    = 13,
  localparam int unsigned TIM_W  = 4 * FLD_W,
  localparam int unsigned XFER_W = N_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_word_i,
  output logic              cmd_ready_o,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              wdata_ack_o,
  input  logic [TIM_W-1:0]  cmd_tim0_i,
  input  logic [TIM_W-1:0]  dat_tim0_i,
  input  logic [TIM_W-1:0]  cmd_tim1_i,
  input  logic [TIM_W-1:0]  dat_tim1_i,
  input  logic [1:0]        iordy_en_i,
  input  logic              err_clr_i,
  input  logic              iordy_i,
  input  logic [DATA_W-1:0] dd_i,
  output logic [DATA_W-1:0] dd_o_o,
  output logic              dd_oe_o,
  output logic [1:0]        cs_n_o,
  output logic [2:0]        da_o,
  output logic              dior_n_o,
  output logic              diow_n_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_valid_o,
  output logic              busy_o,
  output logic              dev_sel_o,
  output logic [XFER_W-1:0] xfer_cnt_o,
  output logic              err_o
);
  cmd_kind_e         kind_d, kind_q;
  logic [1:0]        cs_d, cs_q;
  logic [2:0]        da_d, da_q;
  logic [7:0]        byte_d;
  logic [N_W-1:0]    count_d;
  logic              dev_d, blk_d;
  logic              dev_q, blk_q, err_q;
  logic [DATA_W-1:0] dd_q, rdata_q;
  logic              rvalid_q, ack_q;
  phase_e            phase;
  logic              strobe_end, cyc_end, more;
  logic              accept, is_reg_d, is_dat_d, start, wd_take;
  logic              rd_q, wr_q, addr_ph;
  logic [TIM_W-1:0]  tim_sel;
  logic [XFER_W-1:0] words_d;

  ata_cmd_decode #(.N_W(N_W)) u_dec (
    .word_i (cmd_word_i),
    .kind_o (kind_d),
    .cs_n_o (cs_d),
    .da_o   (da_d),
    .byte_o (byte_d),
    .count_o(count_d),
    .dev_o  (dev_d),
    .blk_o  (blk_d)
  );

  assign accept   = cmd_valid_i && (phase == PH_IDLE);
  assign is_reg_d = (kind_d == CK_REG_RD) || (kind_d == CK_REG_WR);
  assign is_dat_d = (kind_d == CK_DAT_RD) || (kind_d == CK_DAT_WR);
  assign start    = accept && (is_reg_d || is_dat_d);

  always_comb begin
    if (is_reg_d) tim_sel = dev_q ? cmd_tim1_i : cmd_tim0_i;
    else          tim_sel = dev_q ? dat_tim1_i : dat_tim0_i;
  end

  always_comb begin
    words_d = XFER_W'(1);
    if (is_dat_d) begin
      words_d = XFER_W'(count_d) + XFER_W'(1);
      if (blk_q) words_d = words_d << 2;
    end
  end

  ata_phase_engine #(.FLD_W(FLD_W)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .again_i     (more),
    .tim_i       (tim_sel),
    .iordy_gate_i(!iordy_en_i[dev_q] || iordy_i),
    .phase_o     (phase),
    .strobe_end_o(strobe_end),
    .cyc_end_o   (cyc_end)
  );

  ata_xfer_cnt #(.XFER_W(XFER_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start),
    .load_val_i(words_d),
    .dec_i     (cyc_end),
    .cnt_o     (xfer_cnt_o),
    .more_o    (more)
  );

  assign wd_take = (start && kind_d == CK_DAT_WR) ||
                   (cyc_end && more && kind_q == CK_DAT_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q   <= CK_BAD;
      cs_q     <= 2'b11;
      da_q     <= '0;
      dev_q    <= 1'b0;
      blk_q    <= 1'b0;
      err_q    <= 1'b0;
      dd_q     <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      ack_q    <= wd_take;
      if (start) begin
        kind_q <= kind_d;
        cs_q   <= is_reg_d ? cs_d : 2'b10;
        da_q   <= is_reg_d ? da_d : 3'd0;
        if (kind_d == CK_REG_WR) dd_q <= DATA_W'(byte_d);
      end
      if (wd_take) dd_q <= wdata_i;
      if (accept && kind_d == CK_SETDEV) begin
        dev_q <= dev_d;
        blk_q <= blk_d;
      end
      // a new error in the same clock as a clear wins
      if (accept && kind_d == CK_BAD) err_q <= 1'b1;
      else if (err_clr_i)             err_q <= 1'b0;
      if (strobe_end && rd_q) begin
        rdata_q  <= dd_i;
        rvalid_q <= 1'b1;
      end
    end
  end

  assign rd_q    = (kind_q == CK_REG_RD) || (kind_q == CK_DAT_RD);
  assign wr_q    = (kind_q == CK_REG_WR) || (kind_q == CK_DAT_WR);
  assign addr_ph = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);

  assign cmd_ready_o   = (phase == PH_IDLE);
  assign busy_o        = (phase != PH_IDLE);
  assign cs_n_o        = addr_ph ? cs_q : 2'b11;
  assign da_o          = addr_ph ? da_q : 3'd0;
  assign dior_n_o      = !((phase == PH_STROBE) && rd_q);
  assign diow_n_o      = !((phase == PH_STROBE) && wr_q);
  assign dd_oe_o       = addr_ph && wr_q;
  assign dd_o_o        = dd_q;
  assign rdata_o       = rdata_q;
  assign rdata_valid_o = rvalid_q;
  assign wdata_ack_o   = ack_q;
  assign dev_sel_o     = dev_q;
  assign err_o         = err_q;
endmodule

// File: rtl/ata_pio_seq_chk.sv
module ata_pio_seq_chk #(
  parameter int unsigned XFER_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              cmd_ready_o,
  input logic              busy_o,
  input logic              err_o,
  input logic              dior_n_o,
  input logic              diow_n_o,
  input logic [1:0]        cs_n_o,
  input logic              dd_oe_o,
  input logic              rdata_valid_o,
  input logic [XFER_W-1:0] xfer_cnt_o,
  input logic              iordy_i,
  input logic [1:0]        iordy_en_i,
  input logic              dev_sel_o
);
  assert_one_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dior_n_o && !diow_n_o));

  assert_cs_during_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dior_n_o || !diow_n_o) |-> (cs_n_o != 2'b11));

  assert_oe_on_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !diow_n_o |-> dd_oe_o);

  assert_busy_from_accept_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cmd_valid_i && cmd_ready_o));

  assert_err_from_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> ($past(cmd_valid_i && cmd_ready_o) && !busy_o));

  assert_idle_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (xfer_cnt_o == '0));

  assert_rvalid_after_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |-> $rose(dior_n_o));

  assert_iordy_stretch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dior_n_o && !iordy_i && iordy_en_i[dev_sel_o]) |=> !dior_n_o);
endmodule

bind ata_pio_seq ata_pio_seq_chk #(.XFER_W(XFER_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_ready_o  (cmd_ready_o),
  .busy_o       (busy_o),
  .err_o        (err_o),
  .dior_n_o     (dior_n_o),
  .diow_n_o     (diow_n_o),
  .cs_n_o       (cs_n_o),
  .dd_oe_o      (dd_oe_o),
  .rdata_valid_o(rdata_valid_o),
  .xfer_cnt_o   (xfer_cnt_o),
  .iordy_i      (iordy_i),
  .iordy_en_i   (iordy_en_i),
  .dev_sel_o    (dev_sel_o)
);

// File: tb/sim_ata_pio_seq.sv
module sim_ata_pio_seq;
  localparam int NV = 5;
  localparam logic [15:0] TV_CMD   [NV] = '{16'h3700, 16'hAB5C, 16'h4000, 16'h4003, 16'hC002};
  localparam bit          TV_WR    [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam int          TV_STB   [NV] = '{3, 3, 2, 8, 6};
  localparam int          TV_BUSY  [NV] = '{8, 8, 5, 20, 15};
  localparam int          TV_WORDS [NV] = '{1, 0, 1, 4, 3};
  localparam int          TV_XC    [NV] = '{1, 1, 1, 4, 3};
  localparam logic [1:0]  TV_CS    [NV] = '{2'b10, 2'b01, 2'b10, 2'b10, 2'b10};
  localparam logic [2:0]  TV_DA    [NV] = '{3'd7, 3'd3, 3'd0, 3'd0, 3'd0};
  localparam logic [15:0] TV_DATA  [NV] = '{16'h00A5, 16'h005C, 16'h00A5, 16'h00A5, 16'h1234};

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid = 1'b0, err_clr = 1'b0, iordy = 1'b1;
  logic [15:0] cmd_word = '0, wdata = 16'h1234, dd_in = 16'h00A5;
  logic [1:0]  iordy_en = 2'b00;
  logic        cmd_ready, wack, dd_oe, dior_n, diow_n, rvalid, busy, dev_sel, err;
  logic [15:0] dd_out, rdata, xfer_cnt;
  logic [1:0]  cs_n;
  logic [2:0]  da;

  int n_checks = 0, n_fail = 0;
  int n_rd_lo, n_wr_lo, n_busy, n_rv, n_ack, first_cnt;
  logic [1:0]  cs_seen;
  logic [2:0]  da_seen;
  logic [15:0] dd_seen, rd_seen;
  bit          ready_bad;

  always #5 clk = ~clk;

  ata_pio_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_word_i(cmd_word),
    .cmd_ready_o(cmd_ready), .wdata_i(wdata), .wdata_ack_o(wack),
    .cmd_tim0_i(32'h02010302), .dat_tim0_i(32'h01010201),
    .cmd_tim1_i(32'h00000000), .dat_tim1_i(32'h03030303),
    .iordy_en_i(iordy_en), .err_clr_i(err_clr), .iordy_i(iordy), .dd_i(dd_in),
    .dd_o_o(dd_out), .dd_oe_o(dd_oe), .cs_n_o(cs_n), .da_o(da),
    .dior_n_o(dior_n), .diow_n_o(diow_n), .rdata_o(rdata), .rdata_valid_o(rvalid),
    .busy_o(busy), .dev_sel_o(dev_sel), .xfer_cnt_o(xfer_cnt), .err_o(err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // issue one word and observe it until the block is idle again
  task automatic run_cmd(input logic [15:0] w, input int rel);
    int guard;
    n_rd_lo = 0; n_wr_lo = 0; n_busy = 0; n_rv = 0; n_ack = 0;
    cs_seen = 2'b11; da_seen = '0; dd_seen = '0; rd_seen = '0; ready_bad = 0;
    cmd_word = w; cmd_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    first_cnt = int'(xfer_cnt);
    guard = 0;
    while (busy && guard < 5000) begin
      n_busy++;
      if (cmd_ready) ready_bad = 1;
      if (!dior_n) begin n_rd_lo++; cs_seen = cs_n; da_seen = da; end
      if (!diow_n) begin n_wr_lo++; cs_seen = cs_n; da_seen = da; if (dd_oe) dd_seen = dd_out; end
      if (rvalid) begin n_rv++; rd_seen = rdata; end
      if (wack) n_ack++;
      if (rel > 0 && n_rd_lo >= rel) iordy = 1'b1;
      @(negedge clk);
      guard++;
    end
    check(guard < 5000, "run_cmd hang", guard, 0);
  endtask

  initial begin : watchdog
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R11 reset state
    check(!busy && cmd_ready, "R11 idle", busy, 0);
    check(cs_n == 2'b11 && dior_n && diow_n, "R11 bus", {cs_n, dior_n, diow_n}, 4'hF);
    check(!err && xfer_cnt == 0 && !dev_sel, "R11 flags", {err, dev_sel}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table: R1 reg read, R2 reg write, R3 data bursts, R5/R6 bank 0 phase counts
    for (int i = 0; i < NV; i++) begin
      run_cmd(TV_CMD[i], 0);
      check((TV_WR[i] ? n_wr_lo : n_rd_lo) == TV_STB[i], "R6 strobe length",
            TV_WR[i] ? n_wr_lo : n_rd_lo, TV_STB[i]);
      check((TV_WR[i] ? n_rd_lo : n_wr_lo) == 0, "R1 R2 other strobe idle",
            TV_WR[i] ? n_rd_lo : n_wr_lo, 0);
      check(n_busy == TV_BUSY[i], "R5 busy length", n_busy, TV_BUSY[i]);
      check(n_rv + n_ack == TV_WORDS[i], "R3 word count", n_rv + n_ack, TV_WORDS[i]);
      check(cs_seen == TV_CS[i] && da_seen == TV_DA[i], "R1 cs/da",
            {cs_seen, da_seen}, {TV_CS[i], TV_DA[i]});
      check((TV_WR[i] ? dd_seen : rd_seen) == TV_DATA[i], "R8 R2 data",
            TV_WR[i] ? dd_seen : rd_seen, TV_DATA[i]);
      check(first_cnt == TV_XC[i], "R9 initial count", first_cnt, TV_XC[i]);
      check(!ready_bad, "R12 ready low while busy", ready_bad, 0);
    end
    check(xfer_cnt == 0, "R9 idle count", xfer_cnt, 0);

    // R4 select device 1, no bus cycle
    run_cmd(16'h9D01, 0);
    check(n_busy == 0 && dev_sel, "R4 set device 1", {n_busy[3:0], dev_sel}, 1);
    // R5 R6 device 1 zero timing -> four 1-clock phases
    run_cmd(16'h3700, 0);
    check(n_busy == 4 && n_rd_lo == 1, "R6 zero field", {n_busy[7:0], n_rd_lo[7:0]}, 16'h0401);
    run_cmd(16'h4000, 0);
    check(n_busy == 12, "R5 device 1 data bank", n_busy, 12);

    // R4 block mode on device 0
    run_cmd(16'h9D02, 0);
    check(!dev_sel && n_busy == 0, "R4 set device 0 block", dev_sel, 0);
    run_cmd(16'h4001, 0);
    check(first_cnt == 8, "R9 R4 block count", first_cnt, 8);
    check(n_rv == 8 && n_busy == 40, "R4 block burst", n_rv, 8);
    run_cmd(16'h9D00, 0);

    // R7 IORDY stretch when enabled
    iordy_en = 2'b01; iordy = 1'b0;
    run_cmd(16'h3700, 6);
    check(n_rd_lo == 6, "R7 stretched strobe", n_rd_lo, 6);
    check(n_busy == 11, "R7 stretched busy", n_busy, 11);
    // R7 ignored when disabled
    iordy_en = 2'b10; iordy = 1'b0;
    run_cmd(16'h3700, 0);
    check(n_rd_lo == 3, "R7 iordy ignored", n_rd_lo, 3);
    iordy = 1'b1; iordy_en = 2'b00;

    // R10 invalid words
    run_cmd(16'h0000, 0);
    check(n_busy == 0 && err, "R10 bad word 0000", {n_busy[3:0], err}, 1);
    run_cmd(16'h6000, 0);
    check(n_busy == 0 && dior_n && diow_n && cs_n == 2'b11, "R10 bad word 6000", n_busy, 0);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    check(!err, "R10 clear", err, 0);
    run_cmd(16'h2000, 0);
    check(!err && n_rd_lo == 3, "R10 valid after clear", err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule